// File: doc/BRIEF.md
# Power-Save DRAM Refresh Sequencer

This block keeps the frame-buffer DRAM of a display controller refreshed as the controller moves between full operation, light power-save states and deep power-save states. It counts clock-enable strobes from one of three timebases (the main pixel clock, a memory-enable input pin, or a slow power-down clock) and starts a CAS-before-RAS refresh cycle each time the chosen interval has elapsed. It shapes the RAS and CAS control levels directly.

In the active state and the light power-save states, refresh always runs from the main clock as CAS-before-RAS. In the deep state or in suspend, software picks the timebase with a two-bit field. It may also ask for self-refresh. In that case the sequencer parks the DRAM with CAS and RAS held low. It stops issuing cycles until the request is withdrawn. On exit it precharges and gives one catch-up refresh before interval counting starts again.

A rate bit picks the slow (256 rows per 32 ms) or fast (256 rows per 4 ms) schedule. On the main clock, both interval lengths are parameters. On a slow source, the fast rate refreshes on every strobe and the slow rate on every `SLOW_EDGES`-th strobe.

Top module: `psv_refresh_seq`

## Requirements
- R1: While reset is asserted and for the cycles that follow its release until a refresh is due, `ras_n` and `cas_n` are 1 and `refresh_strobe` and `self_refresh` are 0.
- R2: With the main clock as timebase and `rate_slow`=0, a refresh cycle starts once every `MAIN_DIV_FAST` main-clock strobes.
- R3: With the main clock as timebase and `rate_slow`=1, a refresh cycle starts once every `MAIN_DIV_SLOW` main-clock strobes.
- R4: In the deep state (`ps_mode`=4 or `suspend`=1), `clk_src_sel` chooses the timebase: 1 selects `memen_tick`, 2 selects `pdclk_tick`, and 0 or 3 select `main_tick`. On `memen_tick` or `pdclk_tick`, a refresh starts on every strobe when `rate_slow`=0 and on every `SLOW_EDGES`-th strobe when `rate_slow`=1.
- R5: Outside the deep state, `selfref_en` and `clk_src_sel` have no effect. Refresh stays CAS-before-RAS from `main_tick`, and `self_refresh` stays 0.
- R6: In a refresh cycle, `cas_n` falls one clock before `ras_n`. `ras_n` stays low for exactly `RAS_MIN` clocks, and both lines then stay high for at least `PRE_GAP` clocks before `cas_n` falls again.
- R7: In the deep state with `selfref_en`=1, the sequencer lowers `cas_n` and then `ras_n`. It holds both low with `self_refresh`=1 and gives no `refresh_strobe` for as long as the request stays.
- R8: When the self-refresh request is withdrawn, `ras_n` and `cas_n` go high for `PRE_GAP` clocks. One refresh cycle follows at once, and the next one comes a full interval of the chosen timebase after it.
- R9: A change of timebase takes effect only while no refresh cycle is in progress. A RAS pulse under way keeps its full `RAS_MIN` width.
- R10: `refresh_strobe` is high for one clock, on the clock where `cas_n` falls to open a CAS-before-RAS cycle, and at no other time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; all strobes are enables on it |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ps_mode | input | 3 | Power-save state code; 4 is the deep state |
| suspend | input | 1 | Suspend flag; counts as the deep state |
| selfref_en | input | 1 | Request self-refresh while in the deep state |
| rate_slow | input | 1 | 0: 4 ms schedule, 1: 32 ms schedule |
| clk_src_sel | input | 2 | Deep-state timebase: 0/3 main, 1 memory-enable, 2 power-down clock |
| main_tick | input | 1 | One-clock strobe per main-clock period |
| memen_tick | input | 1 | One-clock strobe per rising edge on the memory-enable pin |
| pdclk_tick | input | 1 | One-clock strobe per rising edge of the power-down clock |
| ras_n | output | 1 | Row strobe level, active low |
| cas_n | output | 1 | Column strobe level, active low |
| refresh_strobe | output | 1 | Pulse marking the start of each CAS-before-RAS cycle |
| self_refresh | output | 1 | High while the DRAM is parked in self-refresh |

## Verification
The interval is measured in strobes of the timebase that the requirements predict. The stimulus mixes all eight state codes with suspend, both rate settings and all four selector values, and the three strobe streams run with independent random gaps. A count that matches only the main-clock stream, or only the slow one, shows whether the deep-state decode and the source multiplexer pick the right input. Directed runs add self-refresh with the request set outside the deep state, which must be ignored. They also cover entry and exit in the deep state, with the exit precharge and catch-up cycle counted clock by clock. One run switches the timebase while RAS is low, to show that the pulse keeps its width.

// File: rtl/psv_refresh_pkg.sv
package psv_refresh_pkg;

  typedef enum logic [1:0] {
    SRC_MAIN  = 2'd0,
    SRC_MEMEN = 2'd1,
    SRC_PDCLK = 2'd2
  } src_e;

  typedef enum logic [2:0] {
    ST_IDLE    = 3'd0,
    ST_CBR_CAS = 3'd1,
    ST_CBR_RAS = 3'd2,
    ST_PRECH   = 3'd3,
    ST_SR_CAS  = 3'd4,
    ST_SR_HOLD = 3'd5,
    ST_SR_EXIT = 3'd6
  } seq_state_e;

endpackage

// File: rtl/psv_mode_decode.sv
module psv_mode_decode
  import psv_refresh_pkg::*;
#(
  parameter logic [2:0] DEEP_CODE = 3'd4
) (
  input  logic [2:0] ps_mode_i,
  input  logic       suspend_i,
  input  logic       selfref_en_i,
  input  logic [1:0] src_code_i,
  output logic       want_sr_o,
  output src_e       src_eff_o
);

  logic deep;

  always_comb begin
    deep      = suspend_i || (ps_mode_i == DEEP_CODE);
    want_sr_o = deep && selfref_en_i;
    src_eff_o = SRC_MAIN;
    if (deep) begin
      case (src_code_i)
        2'd1:    src_eff_o = SRC_MEMEN;
        2'd2:    src_eff_o = SRC_PDCLK;
        default: src_eff_o = SRC_MAIN;
      endcase
    end
  end

endmodule

// File: rtl/psv_refresh_timebase.sv
module psv_refresh_timebase
  import psv_refresh_pkg::*;
#(
  parameter int MAIN_DIV_FAST = 438,
  parameter int MAIN_DIV_SLOW = 3500,
  parameter int SLOW_EDGES    = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  src_e src_sel_i,
  input  logic rate_slow_i,
  input  logic main_tick_i,
  input  logic memen_tick_i,
  input  logic pdclk_tick_i,
  input  logic seq_idle_i,
  input  logic restart_i,
  output logic due_o
);

  localparam int MAX_A = (MAIN_DIV_SLOW > MAIN_DIV_FAST) ? MAIN_DIV_SLOW : MAIN_DIV_FAST;
  localparam int MAX_L = (MAX_A > SLOW_EDGES) ? MAX_A : SLOW_EDGES;
  localparam int CW    = $clog2(MAX_L + 1);

  src_e          src_q, src_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          tick_sel, src_chg;

  function automatic logic [CW-1:0] reload_val(src_e s, logic slow);
    if (s == SRC_MAIN) return slow ? CW'(MAIN_DIV_SLOW - 1) : CW'(MAIN_DIV_FAST - 1);
    return slow ? CW'(SLOW_EDGES - 1) : '0;
  endfunction

  always_comb begin
    case (src_q)
      SRC_MEMEN: tick_sel = memen_tick_i;
      SRC_PDCLK: tick_sel = pdclk_tick_i;
      default:   tick_sel = main_tick_i;
    endcase
    src_chg = seq_idle_i && (src_sel_i != src_q);
    src_d   = seq_idle_i ? src_sel_i : src_q;
    due_o   = tick_sel && (cnt_q == '0);
    cnt_d   = cnt_q;
    if (restart_i || src_chg)
      cnt_d = reload_val(src_d, rate_slow_i);
    else if (tick_sel)
      cnt_d = (cnt_q == '0) ? reload_val(src_q, rate_slow_i) : cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_q <= SRC_MAIN;
      cnt_q <= CW'(MAIN_DIV_FAST - 1);
    end else begin
      src_q <= src_d;
      cnt_q <= cnt_d;
    end
  end

  // R9: the timebase holds while a refresh or self-refresh sequence is under way
  assert_src_stable_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !seq_idle_i |=> $stable(src_q));

endmodule

// File: rtl/psv_refresh_fsm.sv
module psv_refresh_fsm
  import psv_refresh_pkg::*;
#(
  parameter int RAS_MIN = 4,
  parameter int PRE_GAP = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic due_i,
  input  logic want_sr_i,
  output logic ras_n_o,
  output logic cas_n_o,
  output logic strobe_o,
  output logic idle_o,
  output logic restart_o,
  output logic in_sr_o
);

  localparam int TMAX = (RAS_MIN > PRE_GAP) ? RAS_MIN : PRE_GAP;
  localparam int TW   = $clog2(TMAX + 1);

  seq_state_e    state_q, state_d;
  logic [TW-1:0] tmr_q, tmr_d;
  logic          pend_q, pend_d;

  always_comb begin
    state_d = state_q;
    tmr_d   = tmr_q;
    pend_d  = pend_q;
    case (state_q)
      ST_IDLE: begin
        if (want_sr_i) begin
          state_d = ST_SR_CAS;
          pend_d  = 1'b0;
        end else if (due_i || pend_q) begin
          state_d = ST_CBR_CAS;
          pend_d  = 1'b0;
        end
      end
      ST_CBR_CAS: begin
        pend_d  = pend_q | due_i;
        state_d = ST_CBR_RAS;
        tmr_d   = TW'(RAS_MIN - 1);
      end
      ST_CBR_RAS: begin
        pend_d = pend_q | due_i;
        if (tmr_q == '0) begin
          state_d = ST_PRECH;
          tmr_d   = TW'(PRE_GAP - 1);
        end else begin
          tmr_d = tmr_q - 1'b1;
        end
      end
      ST_PRECH: begin
        pend_d = pend_q | due_i;
        if (tmr_q == '0) state_d = ST_IDLE;
        else             tmr_d   = tmr_q - 1'b1;
      end
      ST_SR_CAS: begin
        pend_d  = 1'b0;
        state_d = ST_SR_HOLD;
      end
      ST_SR_HOLD: begin
        pend_d = 1'b0;
        if (!want_sr_i) begin
          state_d = ST_SR_EXIT;
          tmr_d   = TW'(PRE_GAP - 1);
        end
      end
      ST_SR_EXIT: begin
        pend_d = 1'b0;
        if (tmr_q == '0) state_d = ST_CBR_CAS;
        else             tmr_d   = tmr_q - 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      tmr_q   <= '0;
      pend_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      tmr_q   <= tmr_d;
      pend_q  <= pend_d;
    end
  end

  always_comb begin
    ras_n_o   = !((state_q == ST_CBR_RAS) || (state_q == ST_SR_HOLD));
    cas_n_o   = !((state_q == ST_CBR_CAS) || (state_q == ST_CBR_RAS) ||
                  (state_q == ST_SR_CAS)  || (state_q == ST_SR_HOLD));
    strobe_o  = (state_q == ST_CBR_CAS);
    idle_o    = (state_q == ST_IDLE);
    restart_o = (state_q == ST_SR_EXIT) && (tmr_q == '0);
    in_sr_o   = (state_q == ST_SR_HOLD);
  end

  // R6: RAS only falls while CAS is already low and was low the clock before
  assert_cas_lead_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(ras_n_o) |-> (!cas_n_o && $past(!cas_n_o)));

  // R10: the cycle-start strobe never lasts longer than one clock
  assert_strobe_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
    strobe_o |=> !strobe_o);

  // R7: self-refresh is held while the request persists
  assert_sr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (in_sr_o && want_sr_i) |=> (in_sr_o && !ras_n_o && !cas_n_o));

  // R8: the end of the exit precharge is followed by a refresh cycle
  assert_exit_cbr_R8: assert property (@(posedge clk) disable iff (!rst_n)
    restart_o |=> strobe_o);

endmodule

// File: rtl/psv_refresh_seq.sv
module psv_refresh_seq
  import psv_refresh_pkg::*;
#(
  parameter int         MAIN_DIV_FAST = 438,
  parameter int         MAIN_DIV_SLOW = 3500,
  parameter int         SLOW_EDGES    = 8,
  parameter int         RAS_MIN       = 4,
  parameter int         PRE_GAP       = 3,
  parameter logic [2:0] DEEP_CODE     = 3'd4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [2:0] ps_mode,
  input  logic       suspend,
  input  logic       selfref_en,
  input  logic       rate_slow,
  input  logic [1:0] clk_src_sel,
  input  logic       main_tick,
  input  logic       memen_tick,
  input  logic       pdclk_tick,
  output logic       ras_n,
  output logic       cas_n,
  output logic       refresh_strobe,
  output logic       self_refresh
);

  logic [1:0] rst_sync_q;
  logic       rst_int_n;
  logic       want_sr, due, seq_idle, restart;
  src_e       src_eff;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  psv_mode_decode #(.DEEP_CODE(DEEP_CODE)) u_decode (
    .ps_mode_i    (ps_mode),
    .suspend_i    (suspend),
    .selfref_en_i (selfref_en),
    .src_code_i   (clk_src_sel),
    .want_sr_o    (want_sr),
    .src_eff_o    (src_eff)
  );

  psv_refresh_timebase #(
    .MAIN_DIV_FAST (MAIN_DIV_FAST),
    .MAIN_DIV_SLOW (MAIN_DIV_SLOW),
    .SLOW_EDGES    (SLOW_EDGES)
  ) u_timebase (
    .clk          (clk),
    .rst_n        (rst_int_n),
    .src_sel_i    (src_eff),
    .rate_slow_i  (rate_slow),
    .main_tick_i  (main_tick),
    .memen_tick_i (memen_tick),
    .pdclk_tick_i (pdclk_tick),
    .seq_idle_i   (seq_idle),
    .restart_i    (restart),
    .due_o        (due)
  );

  psv_refresh_fsm #(
    .RAS_MIN (RAS_MIN),
    .PRE_GAP (PRE_GAP)
  ) u_fsm (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .due_i     (due),
    .want_sr_i (want_sr),
    .ras_n_o   (ras_n),
    .cas_n_o   (cas_n),
    .strobe_o  (refresh_strobe),
    .idle_o    (seq_idle),
    .restart_o (restart),
    .in_sr_o   (self_refresh)
  );

  // R5: one clock after the block has been outside the deep state, it is never in self-refresh
  assert_light_no_sr_R5: assert property (@(posedge clk) disable iff (!rst_int_n)
    ($past(!suspend && ps_mode != DEEP_CODE) && !suspend && ps_mode != DEEP_CODE)
      |-> !self_refresh);

endmodule

// File: tb/test_psv_refresh_seq.sv
module test_psv_refresh_seq;

  localparam int FAST  = 10;
  localparam int SLOW  = 80;
  localparam int EDGES = 8;
  localparam int RASW  = 3;
  localparam int PREG  = 2;

  logic       clk = 1'b0;
  logic       rst_n;
  logic [2:0] ps_mode;
  logic       suspend, selfref_en, rate_slow;
  logic [1:0] clk_src_sel;
  logic       main_tick, memen_tick, pdclk_tick;
  logic       ras_n, cas_n, refresh_strobe, self_refresh;

  always #5 clk = ~clk;

  psv_refresh_seq #(
    .MAIN_DIV_FAST (FAST), .MAIN_DIV_SLOW (SLOW), .SLOW_EDGES (EDGES),
    .RAS_MIN (RASW), .PRE_GAP (PREG), .DEEP_CODE (3'd4)
  ) i_psv_refresh_seq (
    .clk (clk), .rst_n (rst_n), .ps_mode (ps_mode), .suspend (suspend),
    .selfref_en (selfref_en), .rate_slow (rate_slow), .clk_src_sel (clk_src_sel),
    .main_tick (main_tick), .memen_tick (memen_tick), .pdclk_tick (pdclk_tick),
    .ras_n (ras_n), .cas_n (cas_n), .refresh_strobe (refresh_strobe),
    .self_refresh (self_refresh)
  );

  int  errors = 0, checks = 0, cyc = 0;
  int  tick_cnt = 0, good = 0, run = 0, hi_gap = 99;
  int  cd [3];
  bit  skip = 1, chk_iv = 0, sr_phase = 0, lead_pend = 0, ticks_on = 0, done = 0;
  logic prev_ras = 1'b1, prev_cas = 1'b1;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d (cycle %0d)", req, act, exp, cyc);
    end
  endtask

  // expected timebase: 0 main, 1 memory-enable, 2 power-down clock
  function automatic int exp_src();
    if (suspend || ps_mode == 3'd4) begin
      if (clk_src_sel == 2'd1) return 1;
      if (clk_src_sel == 2'd2) return 2;
    end
    return 0;
  endfunction

  function automatic int exp_iv();
    if (exp_src() == 0) return rate_slow ? SLOW : FAST;
    return rate_slow ? EDGES : 1;
  endfunction

  function automatic string req_tag();
    if (exp_src() != 0) return "R4 slow-source interval";
    if (!(suspend || ps_mode == 3'd4) && (selfref_en || clk_src_sel != 0))
      return rate_slow ? "R5/R3 main interval" : "R5/R2 main interval";
    return rate_slow ? "R3 main slow interval" : "R2 main fast interval";
  endfunction

  task automatic monitor();
    bit cas_fell, ras_rose;
    cyc++;
    cas_fell = prev_cas && !cas_n;
    ras_rose = !prev_ras && ras_n;
    if (!sr_phase)
      chk(refresh_strobe == (cas_fell && ras_n), "R10 strobe marks CAS fall",
          refresh_strobe, cas_fell && ras_n);
    if (lead_pend) begin
      chk(!ras_n, "R6 RAS one clock after CAS", ras_n, 0);
      lead_pend = 0;
    end
    if (cas_fell && ras_n) begin
      chk(hi_gap >= PREG, "R6 precharge gap", hi_gap, PREG);
      lead_pend = 1;
    end
    if (!ras_n) run++;
    if (ras_rose) begin
      if (!sr_phase) chk(run == RASW, "R6 RAS width", run, RASW);
      run = 0;
      hi_gap = 0;
    end
    if (ras_n && cas_n) hi_gap++;
    if (refresh_strobe) begin
      if (chk_iv && !skip) begin
        chk(tick_cnt == exp_iv(), req_tag(), tick_cnt, exp_iv());
        good++;
      end
      skip = 0;
      tick_cnt = 0;
    end
    prev_ras = ras_n;
    prev_cas = cas_n;
  endtask

  task automatic drive_ticks();
    logic [2:0] t;
    t = '0;
    if (ticks_on) begin
      for (int i = 0; i < 3; i++) begin
        cd[i]--;
        if (cd[i] <= 0) begin
          t[i] = 1'b1;
          cd[i] = $urandom_range(11, 8);
          if (i == exp_src()) tick_cnt++;
        end
      end
    end
    main_tick  = t[0];
    memen_tick = t[1];
    pdclk_tick = t[2];
  endtask

  task automatic step();
    @(negedge clk);
    monitor();
    drive_ticks();
  endtask

  task automatic set_cfg(input logic [2:0] pm, input logic su, input logic sr,
                         input logic rs, input logic [1:0] sel);
    ps_mode = pm; suspend = su; selfref_en = sr; rate_slow = rs; clk_src_sel = sel;
    skip = 1;
    tick_cnt = 0;
  endtask

  task automatic run_strobes(input int n, input int budget);
    good = 0;
    for (int k = 0; k < budget && good < n; k++) step();
  endtask

  always @(posedge clk) begin
    if (!done && cyc > 190000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 190000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    int srun;
    int got;
    rst_n = 1'b0;
    main_tick = 0; memen_tick = 0; pdclk_tick = 0;
    cd[0] = 3; cd[1] = 5; cd[2] = 7;
    set_cfg(3'd0, 0, 0, 0, 2'd0);
    // R1: reset state
    for (int k = 0; k < 4; k++) begin
      step();
      chk(ras_n && cas_n && !refresh_strobe && !self_refresh, "R1 reset levels",
          {ras_n, cas_n, refresh_strobe, self_refresh}, 4'b1100);
    end
    rst_n = 1'b1;
    for (int k = 0; k < 4; k++) begin
      step();
      chk(ras_n && cas_n && !refresh_strobe, "R1 idle after release",
          {ras_n, cas_n, refresh_strobe}, 3'b110);
    end
    ticks_on = 1;
    chk_iv = 1;

    // R2 / R3 directed on the main clock
    set_cfg(3'd0, 0, 0, 0, 2'd0);
    run_strobes(3, 2000);
    chk(good == 3, "R2 strobes seen", good, 3);
    set_cfg(3'd1, 0, 0, 1, 2'd0);
    run_strobes(2, 4000);
    chk(good == 2, "R3 strobes seen", good, 2);

    // R5: light state ignores self-refresh and the source selector
    set_cfg(3'd5, 0, 1, 0, 2'd2);
    run_strobes(3, 2000);
    chk(good == 3 && !self_refresh, "R5 light state stays CBR on main", good, 3);

    // R4: power-down clock, both rates
    set_cfg(3'd4, 0, 0, 0, 2'd2);
    run_strobes(4, 1000);
    chk(good == 4, "R4 pdclk fast strobes", good, 4);
    set_cfg(3'd2, 1, 0, 1, 2'd1);
    run_strobes(2, 1000);
    chk(good == 2, "R4 memen slow strobes", good, 2);

    // R9: switch the timebase while RAS is low
    set_cfg(3'd4, 0, 0, 0, 2'd0);
    for (int k = 0; k < 400 && ras_n; k++) step();
    clk_src_sel = 2'd2;
    skip = 1;
    tick_cnt = 0;
    srun = 1;
    for (int k = 0; k < 20 && !ras_n; k++) begin
      step();
      if (!ras_n) srun++;
    end
    chk(srun == RASW, "R9 RAS pulse kept across source change", srun, RASW);
    run_strobes(3, 1000);
    chk(good == 3, "R9 new source in use", good, 3);

    // R7 / R8: self-refresh entry, hold and exit
    set_cfg(3'd4, 0, 0, 0, 2'd2);
    run_strobes(2, 1000);
    sr_phase = 1;
    chk_iv = 0;
    selfref_en = 1'b1;
    for (int k = 0; k < 20 && !self_refresh; k++) step();
    chk(self_refresh, "R7 self-refresh entered", self_refresh, 1);
    got = 0;
    for (int k = 0; k < 300; k++) begin
      step();
      if (refresh_strobe || ras_n || cas_n || !self_refresh) got++;
    end
    chk(got == 0, "R7 lines held low, no strobes", got, 0);
    selfref_en = 1'b0;
    for (int k = 1; k <= PREG; k++) begin
      step();
      if (k == 1) sr_phase = 0;
      chk(ras_n && cas_n && !refresh_strobe, "R8 exit precharge",
          {ras_n, cas_n, refresh_strobe}, 3'b110);
    end
    step();
    chk(refresh_strobe, "R8 catch-up refresh after exit", refresh_strobe, 1);
    chk_iv = 1;
    skip = 0;
    run_strobes(2, 1000);
    chk(good == 2, "R8 interval resumes", good, 2);

    // random configurations; self-refresh only requested outside the deep state
    for (int n = 0; n < 30; n++) begin
      logic [2:0] pm;
      logic su, sr;
      pm = 3'($urandom_range(7, 0));
      su = ($urandom_range(3, 0) == 0);
      sr = 1'($urandom_range(1, 0));
      if (su || pm == 3'd4) sr = 1'b0;
      set_cfg(pm, su, sr, 1'($urandom_range(1, 0)), 2'($urandom_range(3, 0)));
      run_strobes(2, 3000);
      chk(good == 2, req_tag(), good, 2);
    end

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
  end

endmodule